// File: doc/BRIEF.md
# Rotating Register Window Remapper

This block is one pipeline stage placed between instruction decode and register read. It renames the register indices of every instruction that passes through it. The index space has 64 entries. The lower half, indices 0 to 31, is never renamed. The upper half, indices 32 to 63, is treated as a circular window. That window is shifted by an offset that always moves in steps of two registers, so an even/odd register pair stays a pair after renaming.

The offset lives inside the stage. A rotate instruction adds its immediate amount to the offset, and the sum wraps modulo the window size. Each instruction has two source fields and one destination field. All three are renamed in the same cycle with the same offset. The renamed index of each field's pair partner is also produced.

The result is registered, so the stage adds one cycle of latency. Both sides use a valid/ready handshake. Throughput is one instruction per cycle.

Top module: `rot_remap`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted and after it is released, `out_valid` is low and the offset is zero, so the first instructions pass with every index unchanged.
- R2: Any index field with bit 5 clear (0..31) leaves the stage with the same value.
- R3: An index r in 32..63 leaves the stage as 32 + ((r - 32 + off) mod 32), where off is the current offset.
- R4: An accepted rotate instruction (`in_rot` = 1) sets off = (off + (in_amt with bit 0 cleared)) mod 32. Bit 0 of `in_amt` has no effect, and the sum wraps without saturating.
- R5: A rotate instruction's own fields are renamed with the offset that held before it. Its update applies from the next accepted instruction onward.
- R6: The two sources and the destination use one offset value. Each `*_pair` output equals the renamed value of the field's index with bit 0 inverted.
- R7: An instruction accepted at a clock edge appears on the outputs right after that edge, with `out_valid` high and `out_op` equal to the accepted `in_op`.
- R8: While `out_valid` is high and `out_ready` is low, every output holds. A rotate waiting at the input is not applied until it is accepted, and it is applied exactly once.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream offers an instruction |
| in_ready | output | 1 | Stage can take an instruction this cycle |
| in_rot | input | 1 | Instruction is a rotate |
| in_amt | input | 5 | Rotate amount (bit 0 ignored) |
| in_op | input | OP_W | Opaque instruction payload |
| in_sa | input | 6 | First source index |
| in_sb | input | 6 | Second source index |
| in_dst | input | 6 | Destination index |
| out_valid | output | 1 | Renamed instruction available |
| out_ready | input | 1 | Downstream takes the instruction |
| out_op | output | OP_W | Payload, delayed one stage |
| out_sa | output | 6 | Renamed first source |
| out_sa_pair | output | 6 | Renamed partner of first source |
| out_sb | output | 6 | Renamed second source |
| out_sb_pair | output | 6 | Renamed partner of second source |
| out_dst | output | 6 | Renamed destination |
| out_dst_pair | output | 6 | Renamed partner of destination |

## Verification
Two things can happen in the same cycle: an instruction is renamed, and the offset moves. This happens whenever a rotate is accepted, because the rotate itself must still see the old offset. The same collision is forced during backpressure: a rotate is held at the input while the output stalls, then released. The check is that the offset moves exactly once, on the accepting edge.

A behavioural model in the bench, with its own offset and output slot, is compared against every output on every cycle. Random stall and rotate patterns make the two events coincide often, including amounts that wrap and amounts with bit 0 set.

// File: rtl/rot_remap.sv
module rot_remap #(
  parameter int IDX_W = 6,
  parameter int OP_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_rot,
  input  logic [IDX_W-2:0] in_amt,
  input  logic [OP_W-1:0]  in_op,
  input  logic [IDX_W-1:0] in_sa,
  input  logic [IDX_W-1:0] in_sb,
  input  logic [IDX_W-1:0] in_dst,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OP_W-1:0]  out_op,
  output logic [IDX_W-1:0] out_sa,
  output logic [IDX_W-1:0] out_sa_pair,
  output logic [IDX_W-1:0] out_sb,
  output logic [IDX_W-1:0] out_sb_pair,
  output logic [IDX_W-1:0] out_dst,
  output logic [IDX_W-1:0] out_dst_pair
);

  localparam int WIN_W = IDX_W - 1;
  localparam int OFF_W = WIN_W - 1;

  logic [OFF_W-1:0] off;
  logic             take;

  function automatic logic [IDX_W-1:0] remap(input logic [IDX_W-1:0] r,
                                             input logic [OFF_W-1:0] o);
    logic [WIN_W-1:0] w;
    w = r[WIN_W-1:0] + {o, 1'b0};
    return r[IDX_W-1] ? {1'b1, w} : r;
  endfunction

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      off <= '0;
    end else if (take && in_rot) begin
      off <= off + in_amt[WIN_W-1:1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_op       <= '0;
      out_sa       <= '0;
      out_sa_pair  <= '0;
      out_sb       <= '0;
      out_sb_pair  <= '0;
      out_dst      <= '0;
      out_dst_pair <= '0;
    end else if (take) begin
      out_op       <= in_op;
      out_sa       <= remap(in_sa, off);
      out_sa_pair  <= remap(in_sa ^ 1, off);
      out_sb       <= remap(in_sb, off);
      out_sb_pair  <= remap(in_sb ^ 1, off);
      out_dst      <= remap(in_dst, off);
      out_dst_pair <= remap(in_dst ^ 1, off);
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_sa) && $stable(out_sb)
      && $stable(out_dst) && $stable(out_op));

  // R4
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(take && in_rot) |=> $stable(off));

  // R2
  low_pass_chk: assert property (@(posedge clk) disable iff (rst)
    take && !in_sa[IDX_W-1] |=> out_sa == $past(in_sa));

  // R6
  pair_link_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sa_pair == (out_sa ^ 1)) && (out_dst_pair == (out_dst ^ 1)));

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid && out_op == $past(in_op));

endmodule

// File: tb/tb_rot_remap.sv
module tb_rot_remap;
  logic clk = 0, rst = 1;
  logic in_valid = 0, in_rot = 0, out_ready = 1;
  logic [4:0] in_amt = 0;
  logic [7:0] in_op = 0;
  logic [5:0] in_sa = 0, in_sb = 0, in_dst = 0;
  logic in_ready, out_valid;
  logic [7:0] out_op;
  logic [5:0] out_sa, out_sa_pair, out_sb, out_sb_pair, out_dst, out_dst_pair;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rot_remap dut (.clk, .rst, .in_valid, .in_ready, .in_rot, .in_amt, .in_op,
    .in_sa, .in_sb, .in_dst, .out_valid, .out_ready, .out_op, .out_sa,
    .out_sa_pair, .out_sb, .out_sb_pair, .out_dst, .out_dst_pair);

  function automatic int ren(int r, int o);
    if (r < 32) return r;
    return 32 + ((r - 32 + o) % 32);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  int moff = 0;
  bit mv = 0;
  int mop, msa, msap, msb, msbp, md, mdp;

  always @(posedge clk) begin
    if (rst) begin
      mv <= 0; moff <= 0;
    end else if (in_valid && (!mv || out_ready)) begin
      mv <= 1;
      mop <= in_op;
      msa <= ren(in_sa, moff);   msap <= ren(in_sa ^ 1, moff);
      msb <= ren(in_sb, moff);   msbp <= ren(in_sb ^ 1, moff);
      md  <= ren(in_dst, moff);  mdp  <= ren(in_dst ^ 1, moff);
      if (in_rot) moff <= (moff + (in_amt & 30)) % 32;
    end else if (out_ready) mv <= 0;
  end

  always @(negedge clk) if (!rst) begin
    chk(out_valid == mv, "R7/R8 out_valid", out_valid, mv);
    if (mv) begin
      chk(out_op == mop, "R7 op", out_op, mop);
      chk(out_sa == msa, "R2/R3 sa", out_sa, msa);
      chk(out_sb == msb, "R2/R3 sb", out_sb, msb);
      chk(out_dst == md, "R2/R3 dst", out_dst, md);
      chk(out_sa_pair == msap && out_sb_pair == msbp && out_dst_pair == mdp,
          "R6 pairs", out_dst_pair, mdp);
    end
  end

  task automatic xfer(bit rot, int amt, int a, int b, int d);
    in_valid = 1; out_ready = 1; in_rot = rot; in_amt = amt[4:0];
    in_sa = a[5:0]; in_sb = b[5:0]; in_dst = d[5:0]; in_op = in_op + 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 reset valid", out_valid, 0);
    chk(in_ready == 1, "R1 reset ready", in_ready, 1);
    rst = 0;
    xfer(0, 0, 40, 5, 63);
    chk(out_sa == 40 && out_dst == 63, "R1 zero offset", out_sa, 40);
    xfer(1, 30, 40, 0, 0);
    chk(out_sa == 40, "R5 rotate uses old offset", out_sa, 40);
    xfer(0, 0, 40, 0, 0);
    chk(out_sa == 38, "R3 offset 30", out_sa, 38);
    xfer(1, 5, 0, 0, 0);
    xfer(0, 0, 63, 7, 62);
    chk(out_sa == 33, "R4 odd amount wraps", out_sa, 33);
    chk(out_sb == 7, "R2 low index", out_sb, 7);
    chk(out_dst == 32 && out_dst_pair == 33, "R6 pair", out_dst_pair, 33);
    xfer(0, 0, 50, 1, 2);
    chk(out_sa == 52, "R3 before stall", out_sa, 52);
    out_ready = 0; in_rot = 1; in_amt = 8; in_sa = 33; in_op = in_op + 1;
    #1 chk(in_ready == 0, "R9 ready low", in_ready, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1 && out_sa == 52, "R8 hold", out_sa, 52);
    end
    out_ready = 1;
    #1 chk(in_ready == 1, "R9 ready high", in_ready, 1);
    @(negedge clk);
    chk(out_sa == 35, "R8 held rotate old offset", out_sa, 35);
    in_rot = 0; in_sa = 32; in_op = in_op + 1;
    @(negedge clk);
    chk(out_sa == 42, "R8 rotate applied once", out_sa, 42);
    in_valid = 0;
    @(negedge clk);
    chk(out_valid == 0, "R7 drain", out_valid, 0);
    for (int i = 0; i < 4000; i++) begin
      in_valid = ($urandom % 4) != 0;
      out_ready = ($urandom % 10) < 7;
      in_rot = ($urandom % 4) == 0;
      in_amt = 5'($urandom);
      in_op = 8'($urandom);
      in_sa = 6'($urandom); in_sb = 6'($urandom); in_dst = 6'($urandom);
      #1 chk(in_ready == (!mv || out_ready), "R9 ready", in_ready, !mv || out_ready);
      @(negedge clk);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule